// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It runs two predictors side by side and uses a third table to pick between them. The first is a per-branch predictor. Each branch address owns a short shift register of its own recent outcomes, and that pattern selects a 3-bit saturating counter. The second is a correlating predictor. One shared shift register holds the most recent resolved outcomes of all branches, and its value selects a 2-bit saturating counter. The selector is a table of 2-bit counters that is also addressed by the shared history. It learns, for each history context, which of the two predictors deserves trust.

A fetch unit presents a branch address on the lookup channel. One cycle later the response channel returns the final guess together with both component guesses. The front end keeps the two component guesses and hands them back on the update channel when the branch resolves, together with the real outcome. Both counter tables are then trained. The selector moves only when the two components disagreed about being right. Both history registers then shift in the outcome. History is changed only at resolution; nothing is changed speculatively.

Lookup and response are valid/ready channels. A lookup is accepted on a clock edge where `lkp_valid` and `lkp_ready` are both high. The response holds its value until `rsp_ready` is high. `lkp_ready` drops while a response is pending and `rsp_ready` is low, so no lookup can overwrite an unread response. The update channel never applies back-pressure.

Top module: `tourney_bp`

## Requirements
- R1: After reset, no response is pending and every history is zero. Every 3-bit counter holds 3 and every 2-bit direction counter holds 1, which is weak not-taken. Every selector counter holds 1, which means "use the per-branch predictor". The first lookup therefore returns 0 for all three predictions.
- R2: A lookup is accepted when `lkp_valid && lkp_ready`, and its response is valid on the next cycle. `lkp_ready` equals `!rsp_valid || rsp_ready`.
- R3: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_taken`, `rsp_local` and `rsp_global` stay unchanged.
- R4: The per-branch history entry is chosen by `pc[11:2]`. That 10-bit history selects one of 1024 3-bit counters, and `rsp_local` is 1 when that counter is 4 or more.
- R5: The 12-bit shared history selects one of 4096 2-bit counters, and `rsp_global` is its high bit.
- R6: The shared history also selects a selector counter. When that counter's high bit is 1, `rsp_taken` takes the correlating guess; otherwise it takes the per-branch guess.
- R7: On an update, the 3-bit counter selected by the branch's current history counts up on taken and down on not-taken, saturating at 7 and 0. The outcome is then shifted into bit 0 of that branch's history.
- R8: On an update, the 2-bit counter at the current shared history counts up or down, saturating at 3 and 0. The outcome is then shifted into bit 0 of the shared history.
- R9: The selector counter at the current shared history counts up (toward correlating, saturating at 3) when only `upd_global_pred` matched the outcome. It counts down (toward per-branch, saturating at 0) when only `upd_local_pred` matched. It stays unchanged when both matched or neither did.
- R10: `upd_ready` is always 1. A lookup accepted on the same edge as an update sees the table state from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lkp_valid | input | 1 | Lookup request present |
| lkp_ready | output | 1 | Lookup can be accepted |
| lkp_pc | input | 32 | Branch address to predict |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_taken | output | 1 | Final direction guess |
| rsp_local | output | 1 | Per-branch component guess |
| rsp_global | output | 1 | Correlating component guess |
| upd_valid | input | 1 | Resolved branch present |
| upd_ready | output | 1 | Always 1 |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome |
| upd_local_pred | input | 1 | Per-branch guess captured at lookup |
| upd_global_pred | input | 1 | Correlating guess captured at lookup |

## Verification
The checks assume that the environment holds `upd_valid` low and keeps the response consumer idle during reset. They also assume that the shared history at update time matches the one seen at lookup. The stimulus meets the second assumption by resolving each branch before the next lookup is issued. Only the directed selector tests feed fabricated component guesses, which steer training into chosen counters. Back-pressure is exercised by holding `rsp_ready` low across several edges while a second lookup waits.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int PC_W   = 32;
  localparam int LIDX_W = 10;
  localparam int LH_W   = 10;
  localparam int LC_W   = 3;
  localparam int GH_W   = 12;
  localparam int GC_W   = 2;

  typedef struct packed {
    logic taken;
    logic loc;
    logic glob;
  } bp_guess_t;
endpackage

// File: rtl/bp_local.sv
module bp_local #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10,
  parameter int CNT_W  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_pred,
  input  logic            up_en,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken
);
  localparam int HIST_N  = 1 << IDX_W;
  localparam int CNT_N   = 1 << HIST_W;
  localparam logic [CNT_W-1:0] CMAX    = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] WEAK_NT = CMAX >> 1;

  logic [HIST_W-1:0] hist_q [HIST_N];
  logic [CNT_W-1:0]  cnt_q  [CNT_N];

  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic [HIST_W-1:0] up_hist;
  logic [CNT_W-1:0]  up_cnt;

  assign lk_idx  = lk_pc[IDX_W+1:2];
  assign up_idx  = up_pc[IDX_W+1:2];
  assign lk_pred = cnt_q[hist_q[lk_idx]][CNT_W-1];
  assign up_hist = hist_q[up_idx];
  assign up_cnt  = cnt_q[up_hist];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < HIST_N; i++) hist_q[i] <= '0;
      for (int i = 0; i < CNT_N; i++)  cnt_q[i]  <= WEAK_NT;
    end else if (up_en) begin
      if (up_taken && up_cnt != CMAX)      cnt_q[up_hist] <= up_cnt + 1'b1;
      else if (!up_taken && up_cnt != '0)  cnt_q[up_hist] <= up_cnt - 1'b1;
      hist_q[up_idx] <= {up_hist[HIST_W-2:0], up_taken};
    end
  end
endmodule

// File: rtl/bp_global.sv
module bp_global #(
  parameter int HIST_W = 12,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  output logic [HIST_W-1:0] ghr,
  output logic              lk_pred,
  input  logic              up_en,
  input  logic              up_taken
);
  localparam int CNT_N = 1 << HIST_W;
  localparam logic [CNT_W-1:0] CMAX    = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] WEAK_NT = CMAX >> 1;

  logic [HIST_W-1:0] ghr_q;
  logic [CNT_W-1:0]  cnt_q [CNT_N];
  logic [CNT_W-1:0]  cur;

  assign ghr     = ghr_q;
  assign cur     = cnt_q[ghr_q];
  assign lk_pred = cur[CNT_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ghr_q <= '0;
      for (int i = 0; i < CNT_N; i++) cnt_q[i] <= WEAK_NT;
    end else if (up_en) begin
      if (up_taken && cur != CMAX)     cnt_q[ghr_q] <= cur + 1'b1;
      else if (!up_taken && cur != '0) cnt_q[ghr_q] <= cur - 1'b1;
      ghr_q <= {ghr_q[HIST_W-2:0], up_taken};
    end
  end
endmodule

// File: rtl/bp_chooser.sv
module bp_chooser #(
  parameter int HIST_W = 12,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HIST_W-1:0] idx,
  output logic              use_global,
  input  logic              up_en,
  input  logic              loc_ok,
  input  logic              glob_ok
);
  localparam int CNT_N = 1 << HIST_W;
  localparam logic [CNT_W-1:0] CMAX     = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] WEAK_LOC = CMAX >> 1;

  logic [CNT_W-1:0] sel_q [CNT_N];
  logic [CNT_W-1:0] cur;

  assign cur        = sel_q[idx];
  assign use_global = cur[CNT_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CNT_N; i++) sel_q[i] <= WEAK_LOC;
    end else if (up_en && (loc_ok != glob_ok)) begin
      if (glob_ok && cur != CMAX)     sel_q[idx] <= cur + 1'b1;
      else if (loc_ok && cur != '0)   sel_q[idx] <= cur - 1'b1;
    end
  end
endmodule

// File: rtl/tourney_bp.sv
module tourney_bp #(
  parameter int PC_W   = bp_pkg::PC_W,
  parameter int LIDX_W = bp_pkg::LIDX_W,
  parameter int LH_W   = bp_pkg::LH_W,
  parameter int LC_W   = bp_pkg::LC_W,
  parameter int GH_W   = bp_pkg::GH_W,
  parameter int GC_W   = bp_pkg::GC_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lkp_valid,
  output logic            lkp_ready,
  input  logic [PC_W-1:0] lkp_pc,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic            rsp_taken,
  output logic            rsp_local,
  output logic            rsp_global,
  input  logic            upd_valid,
  output logic            upd_ready,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic            upd_local_pred,
  input  logic            upd_global_pred
);
  import bp_pkg::*;

  logic            loc_guess, glob_guess, pick_glob;
  logic [GH_W-1:0] ghr;
  logic            accept, upd_en;
  bp_guess_t       guess_d, guess_q;
  logic            valid_q;

  assign upd_ready = 1'b1;
  assign upd_en    = upd_valid;
  assign lkp_ready = !valid_q || rsp_ready;
  assign accept    = lkp_valid && lkp_ready;

  bp_local #(.PC_W(PC_W), .IDX_W(LIDX_W), .HIST_W(LH_W), .CNT_W(LC_W)) u_loc (
    .clk(clk), .rst(rst), .lk_pc(lkp_pc), .lk_pred(loc_guess),
    .up_en(upd_en), .up_pc(upd_pc), .up_taken(upd_taken));

  bp_global #(.HIST_W(GH_W), .CNT_W(GC_W)) u_glob (
    .clk(clk), .rst(rst), .ghr(ghr), .lk_pred(glob_guess),
    .up_en(upd_en), .up_taken(upd_taken));

  bp_chooser #(.HIST_W(GH_W), .CNT_W(GC_W)) u_sel (
    .clk(clk), .rst(rst), .idx(ghr), .use_global(pick_glob),
    .up_en(upd_en), .loc_ok(upd_local_pred == upd_taken),
    .glob_ok(upd_global_pred == upd_taken));

  always_comb begin
    guess_d.loc   = loc_guess;
    guess_d.glob  = glob_guess;
    guess_d.taken = pick_glob ? glob_guess : loc_guess;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      guess_q <= '0;
    end else begin
      if (accept) begin
        valid_q <= 1'b1;
        guess_q <= guess_d;
      end else if (rsp_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign rsp_valid  = valid_q;
  assign rsp_taken  = guess_q.taken;
  assign rsp_local  = guess_q.loc;
  assign rsp_global = guess_q.glob;
endmodule

// File: rtl/tourney_bp_chk.sv
module tourney_bp_chk #(
  parameter int GH_W = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            lkp_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic            rsp_taken,
  input logic            rsp_local,
  input logic            rsp_global,
  input logic            upd_valid,
  input logic            upd_taken,
  input logic [GH_W-1:0] ghr
);
  // R3
  resp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_taken) &&
                                   $stable(rsp_local) && $stable(rsp_global)));

  // R2
  stall_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |-> !lkp_ready);

  // R6
  agree_pick_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_local == rsp_global) |-> (rsp_taken == rsp_local));

  // R8
  hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> (ghr == {$past(ghr[GH_W-2:0]), $past(upd_taken)}));

  // R8
  hist_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> $stable(ghr));
endmodule

bind tourney_bp tourney_bp_chk #(.GH_W(GH_W)) u_chk (
  .clk(clk), .rst(rst), .lkp_ready(lkp_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_taken(rsp_taken), .rsp_local(rsp_local),
  .rsp_global(rsp_global), .upd_valid(upd_valid), .upd_taken(upd_taken),
  .ghr(ghr));

// File: tb/tourney_bp_test.sv
`timescale 1ns/1ps
module tourney_bp_test;
  logic        clk = 0;
  logic        rst;
  logic        lkp_valid, rsp_ready, upd_valid, upd_taken, upd_lp, upd_gp;
  logic [31:0] lkp_pc, upd_pc;
  logic        lkp_ready, rsp_valid, rsp_taken, rsp_local, rsp_global, upd_ready;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  tourney_bp uut (
    .clk(clk), .rst(rst), .lkp_valid(lkp_valid), .lkp_ready(lkp_ready),
    .lkp_pc(lkp_pc), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_taken(rsp_taken), .rsp_local(rsp_local), .rsp_global(rsp_global),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_local_pred(upd_lp), .upd_global_pred(upd_gp));

  // reference state built from the requirements
  logic [9:0]  m_lh [1024];
  logic [2:0]  m_lc [1024];
  logic [1:0]  m_gc [4096];
  logic [1:0]  m_ch [4096];
  logic [11:0] m_ghr;

  // {pc, outcome}
  localparam logic [32:0] VEC [16] = '{
    {32'h0000_0400, 1'b1}, {32'h0000_0400, 1'b1}, {32'h0000_0400, 1'b1},
    {32'h0000_0400, 1'b0}, {32'h0000_0810, 1'b1}, {32'h0000_0810, 1'b0},
    {32'h0000_0c24, 1'b1}, {32'h0000_0c28, 1'b1}, {32'h0000_0c2c, 1'b1},
    {32'h0000_1000, 1'b0}, {32'h0000_1000, 1'b0}, {32'h0000_0810, 1'b1},
    {32'h0000_0c24, 1'b0}, {32'h0000_0c28, 1'b1}, {32'h0000_0c2c, 1'b0},
    {32'h0000_0400, 1'b1}};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; lkp_valid = 0; upd_valid = 0; rsp_ready = 1;
    lkp_pc = 0; upd_pc = 0; upd_taken = 0; upd_lp = 0; upd_gp = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic lookup(input logic [31:0] pc, output logic t, output logic l, output logic g);
    lkp_valid = 1; lkp_pc = pc;
    @(posedge clk);
    @(negedge clk);
    lkp_valid = 0;
    check("R2 rsp_valid", rsp_valid, 1);
    t = rsp_taken; l = rsp_local; g = rsp_global;
  endtask

  task automatic update(input logic [31:0] pc, input logic t, input logic l, input logic g);
    upd_valid = 1; upd_pc = pc; upd_taken = t; upd_lp = l; upd_gp = g;
    @(posedge clk);
    @(negedge clk);
    upd_valid = 0;
  endtask

  task automatic model_reset();
    for (int i = 0; i < 1024; i++) begin m_lh[i] = 0; m_lc[i] = 3; end
    for (int i = 0; i < 4096; i++) begin m_gc[i] = 1; m_ch[i] = 1; end
    m_ghr = 0;
  endtask

  task automatic model_train(input logic [31:0] pc, input logic t, input logic l, input logic g);
    logic [9:0] li;
    li = m_lh[pc[11:2]];
    if (t && m_lc[li] != 7) m_lc[li]++;
    else if (!t && m_lc[li] != 0) m_lc[li]--;
    m_lh[pc[11:2]] = {m_lh[pc[11:2]][8:0], t};
    if (t && m_gc[m_ghr] != 3) m_gc[m_ghr]++;
    else if (!t && m_gc[m_ghr] != 0) m_gc[m_ghr]--;
    if (g == t && l != t && m_ch[m_ghr] != 3) m_ch[m_ghr]++;
    else if (l == t && g != t && m_ch[m_ghr] != 0) m_ch[m_ghr]--;
    m_ghr = {m_ghr[10:0], t};
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic t, l, g, t2, l2, g2;
    do_reset();
    // R1 reset state
    check("R1 rsp_valid after reset", rsp_valid, 0);
    check("R2 lkp_ready idle", lkp_ready, 1);
    check("R10 upd_ready", upd_ready, 1);
    lookup(32'h0000_0104, t, l, g);
    check("R1 first final", t, 0);
    check("R1 first local", l, 0);
    check("R1 first global", g, 0);

    // R9 selector steering, R4/R5/R7/R8 index use
    update(32'h0000_0104, 1, 0, 0);            // both wrong: selector still
    for (int i = 0; i < 12; i++) update(32'h0000_2000, 0, 0, 0);
    lookup(32'h0000_0104, t, l, g);
    check("R4 local uses own history", l, 0);
    check("R5 global counter trained", g, 1);
    check("R6 R9 selector still local", t, 0);
    update(32'h0000_0104, 1, 0, 1);            // only global right
    for (int i = 0; i < 12; i++) update(32'h0000_2000, 0, 0, 0);
    lookup(32'h0000_0104, t, l, g);
    check("R7 local fresh pattern", l, 0);
    check("R8 global counter", g, 1);
    check("R9 selector moved to global", t, 1);
    update(32'h0000_0104, 0, 1, 1);            // both wrong
    lookup(32'h0000_0104, t, l, g);
    check("R9 both wrong leaves selector", t, 1);
    check("R5 global weak taken", g, 1);

    // R3 back-pressure
    rsp_ready = 0;
    lkp_valid = 1; lkp_pc = 32'h0000_0104;
    @(posedge clk); @(negedge clk);
    t = rsp_taken; l = rsp_local; g = rsp_global;
    lkp_pc = 32'h0000_2000;
    repeat (3) @(negedge clk);
    check("R3 held valid", rsp_valid, 1);
    check("R2 lkp_ready low while stalled", lkp_ready, 0);
    check("R3 held taken", rsp_taken, t);
    check("R3 held local", rsp_local, l);
    rsp_ready = 1;
    @(posedge clk); @(negedge clk);
    lkp_valid = 0;
    check("R2 pending lookup taken on release", rsp_valid, 1);
    @(posedge clk); @(negedge clk);
    check("R2 response drained", rsp_valid, 0);

    // R10 lookup coinciding with update sees old state
    do_reset();
    lkp_valid = 1; lkp_pc = 32'h0000_0104;
    upd_valid = 1; upd_pc = 32'h0000_0104; upd_taken = 1; upd_lp = 0; upd_gp = 1;
    @(posedge clk); @(negedge clk);
    lkp_valid = 0; upd_valid = 0;
    check("R10 same-edge lookup old global", rsp_global, 0);
    check("R10 same-edge lookup old final", rsp_taken, 0);

    // vector walk against the reference state
    do_reset();
    model_reset();
    for (int pass = 0; pass < 40; pass++) begin
      for (int k = 0; k < 16; k++) begin
        logic [31:0] pc;
        logic        o, el, eg, et;
        pc = VEC[k][32:1]; o = VEC[k][0];
        el = m_lc[m_lh[pc[11:2]]][2];
        eg = m_gc[m_ghr][1];
        et = m_ch[m_ghr][1] ? eg : el;
        lookup(pc, t2, l2, g2);
        check("R4 R7 local guess", l2, el);
        check("R5 R8 global guess", g2, eg);
        check("R6 R9 final guess", t2, et);
        update(pc, o, l2, g2);
        model_train(pc, o, l2, g2);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule